// File: doc/BRIEF.md
# Two-Entry Register Fall-Through FIFO

A two-word first-word-fall-through queue made only of flip-flops. Each of the two word registers, a head and a tail, carries its own valid flag. The head register drives the read data port directly. The oldest stored word is therefore on the output, with `out_valid` high, before the consumer pops it. A next-state table over the two flags decides, for each register, whether it holds, loads the incoming word, or (for the head only) takes the tail's word.

Both data sides are valid/ready streams. A word moves on the input side in a cycle where `in_valid` and `in_ready` are both high. It leaves on the output side in a cycle where `out_valid` and `out_ready` are both high. `in_ready` drops only when both entries are full and no pop happens in the same cycle. Pushing against a low `in_ready` is an overflow, and popping against a low `out_valid` is an underflow. Each raises a status pulse in that cycle and leaves the stored contents alone. The `BYPASS` parameter adds a combinational path: an empty FIFO shows the incoming word on its output in the same cycle, and hands it straight through when it is popped at once.

Top module: `ffp_fifo2`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `empty` is 1, `full` is 0, and with `in_valid` low `out_valid` is 0.
- R2: A word accepted into an empty FIFO without a pop appears on `out_data` with `out_valid` high in the next cycle and stays there until popped.
- R3: Words leave in the order they were accepted. At most two are held. `full` is 1 exactly when two are held. While full and `out_ready` is low, `in_ready` is 0.
- R4: `in_valid` high while `in_ready` is low raises `overflow` in that same cycle, and the stored words and flags are unchanged.
- R5: `out_ready` high while `out_valid` is low raises `underflow` in that same cycle. If `in_valid` is also low, nothing stored changes.
- R6: With one word held, a push and a pop in the same cycle leave one word held, and that word is the new input.
- R7: With two words held, `in_ready` is 1 while `out_ready` is 1. A pop moves the tail word to the head, and a simultaneous push refills the tail, so the FIFO stays full.
- R8: The state with the tail valid and the head invalid is never reached.
- R9: With `BYPASS` = 1 and the FIFO empty, `in_valid` drives `out_valid` high with `out_data` equal to `in_data` in the same cycle. If `out_ready` is also high, the word passes through and the FIFO stays empty.
- R10: With `BYPASS` = 0 and the FIFO empty, a push together with a pop stores the word, raises `underflow`, and keeps `out_valid` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO accepts a word this cycle |
| in_data | input | WIDTH | Incoming word |
| out_valid | output | 1 | `out_data` holds the oldest word (or the bypassed word) |
| out_ready | input | 1 | Consumer pops the word this cycle |
| out_data | output | WIDTH | Oldest word, shown ahead of the pop |
| empty | output | 1 | No word stored |
| full | output | 1 | Two words stored |
| overflow | output | 1 | Push attempted while `in_ready` is low |
| underflow | output | 1 | Pop attempted while `out_valid` is low |

## Verification
The bench builds two copies at `WIDTH` = 8, one with `BYPASS` = 0 and one with `BYPASS` = 1, and drives both from the same stimulus. The first copy reaches the empty push-with-pop case, where a word is stored and `underflow` pulses. The second reaches the same-cycle pass-through, where the FIFO stays empty. With the narrow width, each word in the vector table can be written as one byte, and random traffic against a queue model still sees a wide spread of values.

// File: rtl/ffp_pkg.sv
package ffp_pkg;
  // Per-register update choice made by the control table
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_LOAD  = 2'd1,
    SLOT_SHIFT = 2'd2
  } slot_op_e;
endpackage

// File: rtl/ffp_slot.sv
module ffp_slot
  import ffp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  slot_op_e         op,
  input  logic [WIDTH-1:0] load_word,
  input  logic [WIDTH-1:0] shift_word,
  output logic [WIDTH-1:0] word_q
);
  // Data needs no reset: validity lives in the control flags
  always_ff @(posedge clk) begin
    unique case (op)
      SLOT_LOAD:  word_q <= load_word;
      SLOT_SHIFT: word_q <= shift_word;
      default:    word_q <= word_q;
    endcase
  end
endmodule

// File: rtl/ffp_ctrl.sv
module ffp_ctrl
  import ffp_pkg::*;
#(
  parameter bit BYPASS = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  logic     out_ready,
  output logic     in_ready,
  output logic     out_valid,
  output logic     head_v,
  output logic     tail_v,
  output slot_op_e head_op,
  output slot_op_e tail_op,
  output logic     overflow,
  output logic     underflow
);
  logic full_w, pass, push, pop;
  logic head_n, tail_n;

  assign full_w    = head_v & tail_v;
  assign in_ready  = ~full_w | out_ready;
  assign out_valid = head_v | (BYPASS & in_valid);
  assign pass      = BYPASS & ~head_v & in_valid & out_ready;
  assign pop       = out_ready & head_v;
  assign push      = in_valid & in_ready & ~pass;
  assign overflow  = in_valid & ~in_ready;
  assign underflow = out_ready & ~out_valid;

  always_comb begin
    head_n  = head_v;
    tail_n  = tail_v;
    head_op = SLOT_HOLD;
    tail_op = SLOT_HOLD;
    unique case ({head_v, tail_v})
      2'b00: begin
        if (push) begin
          head_op = SLOT_LOAD;
          head_n  = 1'b1;
        end
      end
      2'b10: begin
        if (push && pop) begin
          head_op = SLOT_LOAD;
        end else if (push) begin
          tail_op = SLOT_LOAD;
          tail_n  = 1'b1;
        end else if (pop) begin
          head_n = 1'b0;
        end
      end
      2'b11: begin
        if (pop) begin
          head_op = SLOT_SHIFT;
          if (push) tail_op = SLOT_LOAD;
          else      tail_n  = 1'b0;
        end
      end
      default: begin
        head_n = 1'b0;
        tail_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v <= 1'b0;
      tail_v <= 1'b0;
    end else begin
      head_v <= head_n;
      tail_v <= tail_n;
    end
  end

  // R8: orphan tail never reached
  p_no_orphan_tail_r8: assert property (@(posedge clk) disable iff (rst)
    !(tail_v && !head_v));
  // R4: an overflowing cycle leaves the flags untouched
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    overflow |=> $stable({head_v, tail_v}));
  // R5: a lone underflowing pop leaves the flags untouched
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (underflow && !in_valid) |=> $stable({head_v, tail_v}));
  // R3: full without a pop blocks the producer
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (head_v && tail_v && !out_ready) |-> !in_ready);
endmodule

// File: rtl/ffp_fifo2.sv
module ffp_fifo2
  import ffp_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit BYPASS = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  localparam int DEPTH = 2;

  logic             head_v, tail_v;
  slot_op_e         head_op, tail_op;
  slot_op_e         ops  [DEPTH];
  logic [WIDTH-1:0] word [DEPTH];

  ffp_ctrl #(.BYPASS(BYPASS)) ctrl_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .head_v(head_v), .tail_v(tail_v),
    .head_op(head_op), .tail_op(tail_op),
    .overflow(overflow), .underflow(underflow)
  );

  assign ops[0] = head_op;
  assign ops[1] = tail_op;

  // Slot i shifts from slot i+1; the last slot never shifts
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      ffp_slot #(.WIDTH(WIDTH)) slot_i (
        .clk(clk), .op(ops[i]), .load_word(in_data),
        .shift_word(word[i+1]), .word_q(word[i])
      );
    end else begin : g_last
      ffp_slot #(.WIDTH(WIDTH)) slot_i (
        .clk(clk), .op(ops[i]), .load_word(in_data),
        .shift_word(in_data), .word_q(word[i])
      );
    end
  end

  if (BYPASS) begin : g_bypass
    assign out_data = head_v ? word[0] : in_data;
    // R9: pass-through keeps the FIFO empty
    p_pass_keeps_empty_r9: assert property (@(posedge clk) disable iff (rst)
      (!head_v && in_valid && out_ready) |=> !head_v);
  end else begin : g_plain
    assign out_data = word[0];
  end

  assign empty = ~head_v;
  assign full  = head_v & tail_v;

  // R7: a pop from full brings the tail word to the head
  p_head_shift_r7: assert property (@(posedge clk) disable iff (rst)
    (full && out_ready) |=> (out_valid && out_data == $past(word[1])));
  // R2: a word pushed into an empty FIFO shows on the output next cycle
  p_show_ahead_r2: assert property (@(posedge clk) disable iff (rst)
    (empty && in_valid && !out_ready) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: tb/ffp_fifo2_tb_top.sv
module ffp_fifo2_tb_top;
  localparam int W = 8;

  typedef struct packed {
    logic         iv;
    logic         rd;
    logic [W-1:0] din;
    logic         ov;
    logic [W-1:0] dout;
    logic         ir;
    logic         em;
    logic         fu;
    logic         ovf;
    logic         unf;
  } vec_t;

  localparam int NV = 16;
  // Inputs for one cycle and the outputs expected in that cycle (BYPASS=0)
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0}, // R1 idle after reset
    '{1'b0,1'b1,8'h00, 1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1}, // R5 pop empty
    '{1'b1,1'b0,8'h11, 1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0}, // push 11
    '{1'b1,1'b0,8'h22, 1'b1,8'h11, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R2 11 shown
    '{1'b1,1'b0,8'h33, 1'b1,8'h11, 1'b0,1'b0,1'b1,1'b1,1'b0}, // R4 overflow
    '{1'b0,1'b0,8'h00, 1'b1,8'h11, 1'b0,1'b0,1'b1,1'b0,1'b0}, // R4 unchanged
    '{1'b0,1'b1,8'h00, 1'b1,8'h11, 1'b1,1'b0,1'b1,1'b0,1'b0}, // R3 pop 11
    '{1'b1,1'b1,8'h44, 1'b1,8'h22, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 swap
    '{1'b1,1'b0,8'h55, 1'b1,8'h44, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 head is 44
    '{1'b1,1'b1,8'h66, 1'b1,8'h44, 1'b1,1'b0,1'b1,1'b0,1'b0}, // R7 full push+pop
    '{1'b0,1'b1,8'h00, 1'b1,8'h55, 1'b1,1'b0,1'b1,1'b0,1'b0}, // R7 shifted 55
    '{1'b0,1'b1,8'h00, 1'b1,8'h66, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 order 66
    '{1'b1,1'b1,8'h77, 1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1}, // R10 store+underflow
    '{1'b0,1'b0,8'h00, 1'b1,8'h77, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R10 77 stored
    '{1'b0,1'b1,8'h00, 1'b1,8'h77, 1'b1,1'b0,1'b0,1'b0,1'b0}, // pop 77
    '{1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0}  // R8 back to empty
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv = 1'b0, rd = 1'b0;
  logic [W-1:0] din = '0;
  logic a_ir, a_ov, a_em, a_fu, a_ovf, a_unf;
  logic b_ir, b_ov, b_em, b_fu, b_ovf, b_unf;
  logic [W-1:0] a_do, b_do;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ffp_fifo2 #(.WIDTH(W), .BYPASS(1'b0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(a_ir), .in_data(din),
    .out_valid(a_ov), .out_ready(rd), .out_data(a_do), .empty(a_em),
    .full(a_fu), .overflow(a_ovf), .underflow(a_unf));

  ffp_fifo2 #(.WIDTH(W), .BYPASS(1'b1)) dut_bp_i (
    .clk(clk), .rst(rst), .in_valid(iv), .in_ready(b_ir), .in_data(din),
    .out_valid(b_ov), .out_ready(rd), .out_data(b_do), .empty(b_em),
    .full(b_fu), .overflow(b_ovf), .underflow(b_unf));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive after the falling edge, sample shortly before the rising edge
  task automatic drive(input logic v, input logic r, input logic [W-1:0] d);
    @(negedge clk);
    iv = v; rd = r; din = d;
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] q [$];
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    drive(1'b0, 1'b0, '0);
    chk(a_em && !a_fu && !a_ov, "R1 reset flags", {a_em, a_fu, a_ov}, 3'b100);
    chk(b_em && !b_fu && !b_ov, "R1 reset flags bypass", {b_em, b_fu, b_ov}, 3'b100);

    // Vector table on the plain instance
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].iv, VECS[i].rd, VECS[i].din);
      chk({a_ov, a_ir, a_em, a_fu, a_ovf, a_unf} ==
          {VECS[i].ov, VECS[i].ir, VECS[i].em, VECS[i].fu, VECS[i].ovf, VECS[i].unf},
          $sformatf("R3 vector %0d flags", i),
          {a_ov, a_ir, a_em, a_fu, a_ovf, a_unf},
          {VECS[i].ov, VECS[i].ir, VECS[i].em, VECS[i].fu, VECS[i].ovf, VECS[i].unf});
      if (VECS[i].ov)
        chk(a_do == VECS[i].dout, $sformatf("R2 vector %0d data", i), a_do, VECS[i].dout);
    end

    // R9 bypass: fresh reset, then same-cycle show and pass-through
    @(negedge clk); rst = 1'b1; iv = 1'b0; rd = 1'b0;
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 1'b1, 8'h5A);
    chk(b_ov && b_do == 8'h5A && !b_unf, "R9 same-cycle pass", {b_ov, b_do}, {1'b1, 8'h5A});
    drive(1'b0, 1'b0, '0);
    chk(b_em && !b_ov, "R9 stays empty after pass", {b_em, b_ov}, 2'b10);
    drive(1'b1, 1'b0, 8'hA5);
    chk(b_ov && b_do == 8'hA5 && b_em, "R9 shown while empty", {b_ov, b_do, b_em}, {1'b1, 8'hA5, 1'b1});
    drive(1'b0, 1'b0, '0);
    chk(b_ov && b_do == 8'hA5 && !b_em, "R9 stored without pop", {b_ov, b_do, b_em}, {1'b1, 8'hA5, 1'b0});
    drive(1'b0, 1'b1, '0);

    // R3 random traffic against a queue model on the plain instance
    @(negedge clk); rst = 1'b1; iv = 1'b0; rd = 1'b0;
    @(negedge clk); rst = 1'b0;
    q.delete();
    for (int c = 0; c < 2000; c++) begin
      logic v, r, popd;
      logic [W-1:0] d;
      int sz;
      v = ($urandom % 3) != 0;
      r = ($urandom % 2) != 0;
      d = W'($urandom);
      drive(v, r, d);
      sz = q.size();
      chk(a_ov == (sz > 0) && a_fu == (sz == 2) && (sz == 0 || a_do == q[0]),
          "R3 model compare", {a_ov, a_fu, a_do}, {sz > 0, sz == 2, (sz > 0) ? q[0] : a_do});
      popd = r && sz > 0;
      if (popd) void'(q.pop_front());
      if (v && (sz < 2 || r)) q.push_back(d);
    end

    drive(1'b0, 1'b0, '0);
    finish_run();
  end
endmodule